// File: doc/BRIEF.md
# Serial Link Input Frame Transmitter

This block is the transmit half of the codec side of a five-wire audio serial link. On each rising edge of the frame sync line it takes a snapshot of the codec's state. That state is the ready flag, an optional register read result (index and data), the per-slot requests for more playback data, and six record samples with their valid flags. From the snapshot it assembles one 256-bit input frame: a 16-bit tag word followed by twelve 20-bit slots. It then shifts the frame out most significant bit first, one bit per bit clock.

The tag word marks which slots carry meaningful data. Slot 1 echoes the register index and carries the playback request flags, which are active low on the wire. Slot 2 carries the read data. Slots 3 to 8 carry the record samples, left-aligned. Every field with no valid content goes out as zeros. A low-power input forces the serial output low. The bit clock source, the decoder for the opposite direction and the register file are outside this block.

Top module: `aclink_infrm_tx`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sdo` is driven low after that edge, and no frame is in progress once reset is released.
- R2: The first rising clock edge that samples `sync` high after it was low starts a frame. Frame bit 0 appears on `sdo` after that edge, and bit n appears n edges later. After bit 255, `sdo` stays low until the next rising edge of `sync`.
- R3: Tag bits appear at frame positions 0 to 15 as follows. Position 0 is `codec_rdy`. Positions 1 and 2 are both `rd_pend`, marking slots 1 and 2 valid. Positions 3 to 8 are `pcm_vld[0]` to `pcm_vld[5]`, marking slots 3 to 8. Positions 9 to 15 are zero.
- R4: Slot 1 occupies positions 16 to 35. When `rd_pend` is high it carries, in order, a zero, `rd_idx` MSB first, then `~dac_req[0]` to `~dac_req[5]` (requests for slots 3 to 8, sent active low), then six zeros. When `rd_pend` is low the whole slot is zero.
- R5: Slot 2 occupies positions 36 to 55. When `rd_pend` is high it carries `rd_data` MSB first followed by four zeros. Otherwise it is all zero.
- R6: Slot k (3 to 8) starts at position 16+20*(k-1) and carries sample k-3 from `pcm_smp` (bits [(k-3)*SW +: SW]). The sample is sent MSB first, followed by 20-SW zeros when its valid flag is high. The slot is all zero when its valid flag is low.
- R7: Positions 176 to 255 (slots 9 to 12) are always zero.
- R8: When `low_pwr` is high at a rising edge, `sdo` is low after that edge. The frame position keeps advancing underneath.
- R9: All frame content is taken from the inputs at the edge that starts the frame. Input changes later in the frame have no effect on it.
- R10: A new rising edge of `sync` partway through a frame abandons that frame and starts a new one at bit 0 with fresh inputs.
- R11: Holding `sync` high does not restart the frame. Only a low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync; rising transition starts a frame |
| low_pwr | input | 1 | Forces the serial output low |
| codec_rdy | input | 1 | Codec ready flag placed in tag bit 15 |
| rd_pend | input | 1 | A register read result is to be returned this frame |
| rd_idx | input | 7 | Register index echoed in slot 1 |
| rd_data | input | 16 | Register read data for slot 2 |
| dac_req | input | 6 | Active-high playback data requests for slots 3..8 |
| pcm_smp | input | 6*SW | Six record samples, sample i in bits [i*SW +: SW] |
| pcm_vld | input | 6 | Valid flags for the six record samples |
| sdo | output | 1 | Registered serial frame output |

## Verification
The bench builds two copies side by side from the same stimulus. One uses a 16-bit sample width, which exercises the four-bit zero padding at the tail of every record slot. The other uses the full 20-bit width, where a sample fills its slot exactly and any padding bug would shift or drop the last bits. A behavioural bit-queue model predicts each copy's serial output on every clock. The stimulus covers mid-frame input changes, mid-frame resync, a held sync line and low-power windows, so the capture and alignment rules are tested at both widths.

// File: rtl/ac_infrm_pkg.sv
package ac_infrm_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int N_SLOTS   = 12;
  localparam int FRAME_W   = TAG_W + SLOT_W * N_SLOTS;
  localparam int N_PCM     = 6;
  localparam int IDX_W     = 7;
  localparam int RDAT_W    = 16;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  // bit positions counted from the first transmitted bit
  localparam int S1_POS    = TAG_W;
  localparam int S2_POS    = TAG_W + SLOT_W;
  localparam int PCM_POS   = TAG_W + 2 * SLOT_W;
  localparam int TAIL_POS  = PCM_POS + N_PCM * SLOT_W;
  localparam int RD_PAD_W  = SLOT_W - RDAT_W;
endpackage

// File: rtl/ac_sync_edge.sv
module ac_sync_edge (
  input  logic clk,
  input  logic sync,
  output logic start
);
  logic sync_q;

  always_ff @(posedge clk) begin
    sync_q <= sync;
  end

  assign start = sync & ~sync_q;
endmodule

// File: rtl/ac_slot_fmt.sv
module ac_slot_fmt
  import ac_infrm_pkg::*;
#(
  parameter int SW = 18
) (
  input  logic                   codec_rdy,
  input  logic                   rd_pend,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [RDAT_W-1:0]      rd_data,
  input  logic [N_PCM-1:0]       dac_req,
  input  logic [N_PCM*SW-1:0]    pcm_smp,
  input  logic [N_PCM-1:0]       pcm_vld,
  output logic [FRAME_W-1:0]     frame
);
  localparam int PAD = SLOT_W - SW;

  logic [TAG_W-1:0]  tag_w;
  logic [SLOT_W-1:0] s1_w;
  logic [SLOT_W-1:0] s2_w;

  // tag: ready, slot1/slot2 validity, six record slot flags, zero tail
  always_comb begin
    tag_w            = '0;
    tag_w[TAG_W-1]   = codec_rdy;
    tag_w[TAG_W-2]   = rd_pend;
    tag_w[TAG_W-3]   = rd_pend;
    for (int i = 0; i < N_PCM; i++) begin
      tag_w[TAG_W-4-i] = pcm_vld[i];
    end
  end

  // slot 1: zero msb, echoed index, active-low requests, zero tail
  always_comb begin
    s1_w = '0;
    if (rd_pend) begin
      s1_w[SLOT_W-2 -: IDX_W] = rd_idx;
      for (int i = 0; i < N_PCM; i++) begin
        s1_w[SLOT_W-2-IDX_W-i] = ~dac_req[i];
      end
    end
  end

  assign s2_w = rd_pend ? {rd_data, {RD_PAD_W{1'b0}}} : '0;

  assign frame[FRAME_W-1 -: TAG_W]          = tag_w;
  assign frame[FRAME_W-1-S1_POS -: SLOT_W]  = s1_w;
  assign frame[FRAME_W-1-S2_POS -: SLOT_W]  = s2_w;

  for (genvar gi = 0; gi < N_PCM; gi++) begin : g_pcm
    logic [SW-1:0]     smp;
    logic [SLOT_W-1:0] word;
    assign smp  = pcm_smp[gi*SW +: SW];
    assign word = pcm_vld[gi] ? (SLOT_W'(smp) << PAD) : '0;
    assign frame[FRAME_W-1-PCM_POS-gi*SLOT_W -: SLOT_W] = word;
  end

  assign frame[FRAME_W-1-TAIL_POS:0] = '0;
endmodule

// File: rtl/ac_frame_shreg.sv
module ac_frame_shreg #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         low_pwr,
  input  logic [W-1:0] frame,
  output logic         sdo
);
  logic [W-2:0] sh;
  logic         nxt;

  assign nxt = load ? frame[W-1] : sh[W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else begin
      if (load) sh <= frame[W-2:0];
      else      sh <= {sh[W-3:0], 1'b0};
      sdo <= low_pwr ? 1'b0 : nxt;
    end
  end
endmodule

// File: rtl/aclink_infrm_tx.sv
module aclink_infrm_tx
  import ac_infrm_pkg::*;
#(
  parameter int SW = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync,
  input  logic                low_pwr,
  input  logic                codec_rdy,
  input  logic                rd_pend,
  input  logic [6:0]          rd_idx,
  input  logic [15:0]         rd_data,
  input  logic [5:0]          dac_req,
  input  logic [6*SW-1:0]     pcm_smp,
  input  logic [5:0]          pcm_vld,
  output logic                sdo
);
  logic               start;
  logic [FRAME_W-1:0] frame;

  ac_sync_edge u_edge (
    .clk   (clk),
    .sync  (sync),
    .start (start)
  );

  ac_slot_fmt #(.SW(SW)) u_fmt (
    .codec_rdy (codec_rdy),
    .rd_pend   (rd_pend),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .dac_req   (dac_req),
    .pcm_smp   (pcm_smp),
    .pcm_vld   (pcm_vld),
    .frame     (frame)
  );

  ac_frame_shreg #(.W(FRAME_W)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .low_pwr (low_pwr),
    .frame   (frame),
    .sdo     (sdo)
  );
endmodule

// File: rtl/ac_infrm_chk.sv
module ac_infrm_chk
  import ac_infrm_pkg::*;
#(
  parameter int SW = 18
) (
  input logic clk,
  input logic rst,
  input logic sync,
  input logic low_pwr,
  input logic codec_rdy,
  input logic sdo
);
  logic             sync_d;
  logic [CNT_W-1:0] cnt;
  int               off;
  logic             pcm_pad;

  always_ff @(posedge clk) begin
    sync_d <= sync;
  end

  // position of the bit currently on sdo; FRAME_W means idle
  always_ff @(posedge clk) begin
    if (rst)                      cnt <= CNT_W'(FRAME_W);
    else if (sync && !sync_d)     cnt <= '0;
    else if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
  end

  always_comb begin
    off     = int'(cnt) - PCM_POS;
    pcm_pad = (int'(cnt) >= PCM_POS) && (int'(cnt) < TAIL_POS) && ((off % SLOT_W) >= SW);
  end

  AST_RST_LOW: assert property (@(posedge clk) rst |=> !sdo); // R1
  AST_LP_LOW: assert property (@(posedge clk) disable iff (rst) low_pwr |=> !sdo); // R8
  AST_TAG_RDY: assert property (@(posedge clk) disable iff (rst)
    (sync && !sync_d && !low_pwr) |=> (sdo == $past(codec_rdy))); // R3
  AST_TAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) >= TAG_W - 7 && int'(cnt) < TAG_W) |-> !sdo); // R3
  AST_S1_MSB: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) == S1_POS) |-> !sdo); // R4
  AST_S2_PAD: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) >= S2_POS + RDAT_W && int'(cnt) < PCM_POS) |-> !sdo); // R5
  AST_PCM_PAD: assert property (@(posedge clk) disable iff (rst) pcm_pad |-> !sdo); // R6
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) >= TAIL_POS) |-> !sdo); // R7
endmodule

bind aclink_infrm_tx ac_infrm_chk #(.SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync      (sync),
  .low_pwr   (low_pwr),
  .codec_rdy (codec_rdy),
  .sdo       (sdo)
);

// File: tb/sim_aclink_infrm_tx.sv
module sim_aclink_infrm_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst = 1'b1, sync = 1'b0, low_pwr = 1'b0, codec_rdy = 1'b0, rd_pend = 1'b0;
  logic [6:0]  rd_idx = '0;
  logic [15:0] rd_data = '0;
  logic [5:0]  dac_req = '0, pcm_vld = '0;
  logic [19:0] smp [6];
  logic [95:0]  pcm16;
  logic [119:0] pcm20;
  logic sdo16, sdo20;

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      pcm16[i*16 +: 16] = smp[i][19:4];
      pcm20[i*20 +: 20] = smp[i];
    end
  end

  aclink_infrm_tx #(.SW(16)) u0 (
    .clk(clk), .rst(rst), .sync(sync), .low_pwr(low_pwr), .codec_rdy(codec_rdy),
    .rd_pend(rd_pend), .rd_idx(rd_idx), .rd_data(rd_data), .dac_req(dac_req),
    .pcm_smp(pcm16), .pcm_vld(pcm_vld), .sdo(sdo16));

  aclink_infrm_tx #(.SW(20)) u1 (
    .clk(clk), .rst(rst), .sync(sync), .low_pwr(low_pwr), .codec_rdy(codec_rdy),
    .rd_pend(rd_pend), .rd_idx(rd_idx), .rd_data(rd_data), .dac_req(dac_req),
    .pcm_smp(pcm20), .pcm_vld(pcm_vld), .sdo(sdo20));

  // ---------------- reference model ----------------
  bit    q16[$];
  bit    q20[$];
  logic  e16 = 1'b0, e20 = 1'b0;
  logic  sync_m, rst_m = 1'b1, lp_m = 1'b0;
  int    pos = -1;
  int    checks = 0, fails = 0;
  bit    started = 0, done = 0;
  string scen = "R1";

  task automatic push(int which, logic [19:0] v, int n);
    for (int b = n - 1; b >= 0; b--) begin
      if (which == 0) q16.push_back(v[b]);
      else            q20.push_back(v[b]);
    end
  endtask

  task automatic build(int which);
    push(which, 20'(codec_rdy), 1);
    push(which, 20'(rd_pend), 1);
    push(which, 20'(rd_pend), 1);
    for (int i = 0; i < 6; i++) push(which, 20'(pcm_vld[i]), 1);
    push(which, 20'd0, 7);
    if (rd_pend) begin
      push(which, 20'd0, 1);
      push(which, 20'(rd_idx), 7);
      for (int i = 0; i < 6; i++) push(which, 20'(~dac_req[i]), 1);
      push(which, 20'd0, 6);
      push(which, 20'(rd_data), 16);
      push(which, 20'd0, 4);
    end else begin
      push(which, 20'd0, 20);
      push(which, 20'd0, 20);
    end
    for (int i = 0; i < 6; i++) begin
      if (!pcm_vld[i])     push(which, 20'd0, 20);
      else if (which == 0) begin push(which, 20'(smp[i][19:4]), 16); push(which, 20'd0, 4); end
      else                 push(which, smp[i], 20);
    end
    for (int k = 0; k < 4; k++) push(which, 20'd0, 20);
  endtask

  always @(posedge clk) begin
    rst_m = rst;
    lp_m  = low_pwr;
    if (rst) begin
      q16.delete(); q20.delete(); pos = -1; e16 = 1'b0; e20 = 1'b0;
    end else begin
      if (sync && !sync_m) begin
        q16.delete(); q20.delete(); build(0); build(1); pos = 0;
      end else if (pos >= 0 && pos < 256) pos++;
      e16 = (q16.size() > 0) ? q16.pop_front() : 1'b0;
      e20 = (q20.size() > 0) ? q20.pop_front() : 1'b0;
      if (low_pwr) begin e16 = 1'b0; e20 = 1'b0; end
    end
    sync_m  = sync;
    started = 1;
  end

  function automatic string req_of();
    if (rst_m)                 return "R1";
    if (lp_m)                  return "R8";
    if (pos < 0 || pos >= 256) return "R2";
    if (pos < 16)              return "R3";
    if (pos < 36)              return "R4";
    if (pos < 56)              return "R5";
    if (pos < 176)             return "R6";
    return "R7";
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      checks += 2;
      if (sdo16 !== e16) begin
        fails++;
        $display("FAIL %s (%s) sw=16 pos=%0d act=%b exp=%b", req_of(), scen, pos, sdo16, e16);
      end
      if (sdo20 !== e20) begin
        fails++;
        $display("FAIL %s (%s) sw=20 pos=%0d act=%b exp=%b", req_of(), scen, pos, sdo20, e20);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_vals(logic r, logic p, logic [6:0] ix, logic [15:0] d,
                          logic [5:0] dq, logic [5:0] v, logic [19:0] base);
    codec_rdy = r; rd_pend = p; rd_idx = ix; rd_data = d; dac_req = dq; pcm_vld = v;
    for (int i = 0; i < 6; i++) smp[i] = base ^ (20'h1_2345 * 20'(i + 1));
  endtask

  task automatic run_frame(int hi, int total);
    sync = 1'b1;
    repeat (hi) @(negedge clk);
    sync = 1'b0;
    repeat (total - hi) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) smp[i] = '0;
    repeat (4) @(negedge clk);
    checks++;                                   // R1 explicit reset check
    if (sdo16 !== 1'b0 || sdo20 !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset act=%b%b exp=00", sdo16, sdo20);
    end
    rst = 1'b0;
    repeat (3) @(negedge clk);

    scen = "R3";
    set_vals(1, 1, 7'h5A, 16'hBEEF, 6'b101001, 6'b110101, 20'hF0F0F);
    run_frame(16, 270);

    scen = "R4";
    set_vals(0, 0, 7'h7F, 16'hFFFF, 6'b111111, 6'b111111, 20'hAAAAA);
    run_frame(16, 262);

    scen = "R6";
    set_vals(1, 1, 7'h01, 16'h8001, 6'b000000, 6'b000000, 20'hFFFFF);
    run_frame(16, 258);

    scen = "R9";
    set_vals(1, 1, 7'h33, 16'h1234, 6'b010101, 6'b101010, 20'h5A5A5);
    sync = 1'b1;
    repeat (16) @(negedge clk);
    sync = 1'b0;
    repeat (24) @(negedge clk);
    set_vals(0, 0, 7'h4C, 16'hC3C3, 6'b101010, 6'b010101, 20'h0F0F0);
    repeat (230) @(negedge clk);

    scen = "R8";
    set_vals(1, 1, 7'h2B, 16'h7E81, 6'b110011, 6'b111111, 20'h96969);
    sync = 1'b1;
    repeat (16) @(negedge clk);
    sync = 1'b0;
    repeat (40) @(negedge clk);
    low_pwr = 1'b1;
    repeat (50) @(negedge clk);
    low_pwr = 1'b0;
    repeat (170) @(negedge clk);
    low_pwr = 1'b1;
    run_frame(16, 262);
    low_pwr = 1'b0;

    scen = "R10";
    set_vals(1, 0, 7'h11, 16'h0F0F, 6'b001100, 6'b111100, 20'h3C3C3);
    sync = 1'b1;
    repeat (16) @(negedge clk);
    sync = 1'b0;
    repeat (84) @(negedge clk);
    set_vals(0, 1, 7'h6E, 16'hA5A5, 6'b100001, 6'b001111, 20'hC0FFE);
    run_frame(16, 270);

    scen = "R11";
    set_vals(1, 1, 7'h44, 16'h5555, 6'b011110, 6'b100001, 20'h13579);
    sync = 1'b1;
    repeat (320) @(negedge clk);
    sync = 1'b0;
    repeat (4) @(negedge clk);

    scen = "R2";
    for (int f = 0; f < 6; f++) begin
      set_vals(1'($urandom), 1'($urandom), 7'($urandom), 16'($urandom),
               6'($urandom), 6'($urandom), 20'($urandom));
      run_frame(1 + (f % 3) * 10, 256 + f * 3);
    end
    repeat (5) @(negedge clk);
    finish_up();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired act=running exp=finished");
      finish_up();
    end
  end
endmodule